// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block holds the chip-level control words of a device in a bank of 106 32-bit registers. A simple memory-mapped port reaches the bank: a select, a write enable, a word address, write data, registered read data and a one-cycle error pulse. Only whole 32-bit words are accessed. The address port carries the word index, which is the byte offset divided by 4. The byte offsets below are given only for reference.

Register 0 is a protection word. Any write to the range above it and below byte offset 0x104 is dropped unless register 0 holds the unlock value 0x1688A8A8. The protection word itself, and the range from 0x104 upward, can always be written. Some slots can only be read, and one slot is marked write-only. Any access the bank refuses raises the error pulse.

At reset the bank loads a constant table chosen by a silicon-revision parameter. It then places the revision word and two board strap words, taken from input ports, into their slots. Revision 0x02000303 is the only supported value. Any other value stops elaboration.

Top module: `sysctl_keybank`

## Requirements
- R1: While reset is held, every slot loads its table constant, and slots with no table entry load zero. Examples by word index: 16 = 0x000000C0 (DRAM ready), 1 = 0xFFCFFEDC, 105 = 0x00002402, 3 = 0x19FC3E8B, 65 = 0x80000000, 2 = 0xF3F40000, 39 = 0x003FFFF3, 15 = 0x00000001.
- R2: While reset is held, index 31 (offset 0x7C) takes the revision parameter, index 28 (0x70) takes `strap_a` and index 52 (0xD0) takes `strap_b`.
- R3: A write to indices 1 through 64 (byte offsets 0x04 to 0x100) takes effect only while index 0 holds 0x1688A8A8. Otherwise the slot keeps its value and `err` pulses. Writing any other value to index 0 locks the range again for the next write.
- R4: Writes to index 0 and to indices 65 through 105 always take effect and give no error.
- R5: Writes to the read-only indices 5, 20 to 27, 30, 31, 56 and 57 leave the slot unchanged and pulse `err`, whatever the lock state.
- R6: A read of index 48 (offset 0xC0, write-only) pulses `err` and still returns the stored word. Writes to index 48 follow the normal rules.
- R7: A read at index 106 or above returns zero and pulses `err`. A write there changes no slot and pulses `err`.
- R8: Read data and `err` appear one cycle after the select, and `err` lasts that single cycle. A write is visible to a read issued in the next cycle. Both outputs are zero straight after reset.
- R9: In a cycle with no select, `rdata` keeps its value and `err` is low on the following cycle. Accepted accesses give no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the reset table and straps |
| sel | input | 1 | Access request this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word index (byte offset / 4) |
| wdata | input | 32 | Write data |
| strap_a | input | 32 | First board strap word, sampled during reset |
| strap_b | input | 32 | Second board strap word, sampled during reset |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle pulse for a refused or flagged access |

## Verification
The bank is first read in full after reset to compare every slot against the table and the strap values. The same writes are then aimed at protected slots in three phases: before unlocking, after unlocking and after locking again. The difference between these phases separates the key gate from a plain decode fault. A sweep that writes a distinct pattern to every index and reads all of them back shows whether the read-only set and the open upper range are each handled correctly and kept apart. Out-of-range and write-only reads, back-to-back write-then-read pairs and idle cycles test the zero read data, the flagged-but-returned read, the one-cycle latency and the held output.

// File: rtl/sysctl_keybank_pkg.sv
package sysctl_keybank_pkg;

   localparam int unsigned WORD_BYTES    = 4;
   localparam int unsigned IDX_KEY       = 0;
   localparam int unsigned IDX_LOCK_END  = 'h104 / WORD_BYTES;
   localparam int unsigned IDX_STRAP_A   = 'h70 / WORD_BYTES;
   localparam int unsigned IDX_REV       = 'h7C / WORD_BYTES;
   localparam int unsigned IDX_WO        = 'hC0 / WORD_BYTES;
   localparam int unsigned IDX_STRAP_B   = 'hD0 / WORD_BYTES;

   localparam logic [31:0] REV_A      = 32'h0200_0303;
   localparam logic [31:0] UNLOCK_KEY = 32'h1688_A8A8;

   // decision for one access, taken combinationally
   typedef struct packed {
      logic wr_ok;   // write accepted
      logic rd_any;  // a read was requested
      logic rd_ok;   // read targets a real slot
      logic flag;    // refused or flagged access
   } kb_verdict_t;

   function automatic logic is_read_only(input int unsigned idx);
      return (idx == 'h14/4) || (idx >= 'h50/4 && idx <= 'h6C/4) ||
             (idx == 'h78/4) || (idx == IDX_REV) ||
             (idx == 'hE0/4) || (idx == 'hE4/4);
   endfunction

   // constant table of the supported revision, keyed by byte offset
   function automatic logic [31:0] rev_a_reset(input int unsigned idx);
      logic [31:0] v;
      case (idx * WORD_BYTES)
         'h180: v = 32'h0000_007B;
         'h1A4: v = 32'h0000_2402;
         'h004: v = 32'hFFCF_FEDC;
         'h03C: v = 32'h0000_0001;
         'h0A8: v = 32'h000F_FFFF;
         'h008: v = 32'hF3F4_0000;
         'h110: v = 32'h1E60_0000;
         'h00C: v = 32'h19FC_3E8B;
         'h040: v = 32'h0000_00C0;
         'h01C: v = 32'h0002_6108;
         'h160: v = 32'h0000_1903;
         'h020: v = 32'h0003_0291;
         'h024: v = 32'h0000_0291;
         'h0A4: v = 32'hFFFF_0000;
         'h02C: v = 32'h0000_0010;
         'h030, 'h034: v = 32'h2000_1A03;
         'h038: v = 32'h0400_0030;
         'h04C: v = 32'h0000_0023;
         'h074: v = 32'h0000_000E;
         'h07C: v = REV_A;
         'h114: v = 32'hC000_0000;
         'h084: v = 32'h0000_F000;
         'h088: v = 32'h0100_0000;
         'h08C, 'h0E0, 'h0E4: v = 32'h0000_00FF;
         'h090: v = 32'h0000_A000;
         'h09C: v = 32'h003F_FFF3;
         'h104: v = 32'h8000_0000;
         default: v = 32'h0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/kb_access_decode.sv
module kb_access_decode
   import sysctl_keybank_pkg::*;
#(
   parameter int unsigned NUM_REGS = 106,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter logic [31:0] KEY      = UNLOCK_KEY
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] key_q,
   output kb_verdict_t       verdict
);

   localparam logic [ADDR_W:0] LIMIT    = (ADDR_W+1)'(NUM_REGS);
   localparam logic [ADDR_W:0] LOCK_END = (ADDR_W+1)'(IDX_LOCK_END);

   logic in_range, guarded, unlocked, ro, wo;

   always_comb begin
      in_range = {1'b0, addr} < LIMIT;
      guarded  = (addr != '0) && ({1'b0, addr} < LOCK_END);
      unlocked = (key_q == DATA_W'(KEY));
      ro       = is_read_only(int'(addr));
      wo       = ({1'b0, addr} == (ADDR_W+1)'(IDX_WO));

      verdict.wr_ok  = sel & wr & in_range & ~ro & ~(guarded & ~unlocked);
      verdict.rd_any = sel & ~wr;
      verdict.rd_ok  = sel & ~wr & in_range;
      verdict.flag   = sel & (wr ? ~verdict.wr_ok : (~in_range | wo));
   end

endmodule

// File: rtl/kb_slot.sv
module kb_slot #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rst_val,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= rst_val;
      else if (we) q <= wdata;
   end

endmodule

// File: rtl/kb_resp_stage.sv
module kb_resp_stage
   import sysctl_keybank_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  kb_verdict_t       verdict,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         err <= verdict.flag;
         if (verdict.rd_any) rdata <= verdict.rd_ok ? rd_word : '0;
      end
   end

endmodule

// File: rtl/sysctl_keybank.sv
module sysctl_keybank
   import sysctl_keybank_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 106,
   parameter int unsigned ADDR_W   = 8,
   parameter logic [31:0] REVISION = REV_A,
   parameter logic [31:0] KEY      = UNLOCK_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] strap_a,
   input  logic [DATA_W-1:0] strap_b,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);

   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   if (DATA_W != 32) begin : g_bad_width
      $error("sysctl_keybank: DATA_W must be 32");
   end
   if (NUM_REGS > (1 << ADDR_W) || ADDR_W < IDX_W) begin : g_bad_addr
      $error("sysctl_keybank: ADDR_W too small for NUM_REGS");
   end
   if (NUM_REGS <= IDX_STRAP_B || NUM_REGS <= IDX_LOCK_END) begin : g_bad_depth
      $error("sysctl_keybank: NUM_REGS does not cover the fixed slots");
   end
   if (REVISION != REV_A) begin : g_bad_rev
      $error("sysctl_keybank: unsupported silicon revision");
   end

   logic [DATA_W-1:0] slot_q [NUM_REGS];
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] rd_word;
   kb_verdict_t       vd;

   assign idx     = addr[IDX_W-1:0];
   assign rd_word = slot_q[idx];

   kb_access_decode #(
      .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)
   ) u_dec (
      .sel(sel), .wr(wr), .addr(addr),
      .key_q(slot_q[IDX_KEY]), .verdict(vd)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      localparam logic [31:0] TABLE_VAL = rev_a_reset(i);
      logic [DATA_W-1:0] rv;
      logic              we;

      assign we = vd.wr_ok && (idx == IDX_W'(i));

      if (i == IDX_STRAP_A) begin : g_sa
         assign rv = strap_a;
      end else if (i == IDX_STRAP_B) begin : g_sb
         assign rv = strap_b;
      end else if (i == IDX_REV) begin : g_rev
         assign rv = REVISION;
      end else begin : g_tab
         assign rv = TABLE_VAL;
      end

      kb_slot #(.DATA_W(DATA_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .rst_val(rv),
         .we(we), .wdata(wdata), .q(slot_q[i])
      );
   end

   kb_resp_stage #(.DATA_W(DATA_W)) u_resp (
      .clk(clk), .rst_n(rst_n), .verdict(vd),
      .rd_word(rd_word), .rdata(rdata), .err(err)
   );

endmodule

// File: rtl/kb_checker.sv
module kb_checker
   import sysctl_keybank_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 106,
   parameter int unsigned ADDR_W   = 8,
   parameter logic [31:0] KEY      = UNLOCK_KEY
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              wr,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              err
);

   logic [DATA_W-1:0] key_sh;
   logic              oob, guarded;

   assign oob     = int'(addr) >= NUM_REGS;
   assign guarded = (addr != '0) && (int'(addr) < IDX_LOCK_END);

   // shadow of the protection word, built from port traffic
   always_ff @(posedge clk) begin
      if (!rst_n)                          key_sh <= '0;
      else if (sel && wr && addr == '0)    key_sh <= wdata;
   end

   a_r3_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
      sel && wr && guarded && key_sh != DATA_W'(KEY) |=> err);

   a_r4_key_write_open: assert property (@(posedge clk) disable iff (!rst_n)
      sel && wr && addr == '0 |=> !err);

   a_r5_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
      sel && wr && is_read_only(int'(addr)) |=> err);

   a_r6_wo_read: assert property (@(posedge clk) disable iff (!rst_n)
      sel && !wr && int'(addr) == IDX_WO |=> err);

   a_r7_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
      sel && !wr && oob |=> err && rdata == '0);

   a_r7_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
      sel && wr && oob |=> err);

   a_r8_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(sel));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !err && $stable(rdata));

endmodule

bind sysctl_keybank kb_checker #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .KEY(KEY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
   .wdata(wdata), .rdata(rdata), .err(err)
);

// File: tb/sim_sysctl_keybank.sv
module sim_sysctl_keybank;

   localparam int NREG = 106;
   localparam logic [31:0] KEYV = 32'h1688A8A8;
   localparam logic [31:0] REVV = 32'h02000303;
   localparam logic [31:0] SA   = 32'hA5A5_0001;
   localparam logic [31:0] SB   = 32'h0000_5A5A;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        sel = 0, wr = 0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        err;

   always #5 clk = ~clk;

   sysctl_keybank u0 (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
      .wdata(wdata), .strap_a(SA), .strap_b(SB), .rdata(rdata), .err(err)
   );

   int checks = 0, errors = 0;
   bit done = 0;
   logic [31:0] mdl [NREG];
   logic [31:0] exp_rdata = '0;
   logic        exp_err = 0;
   string       prev_tag = "R8 reset state";

   function automatic logic [31:0] ref_rst(int a);
      case (a * 4)
         'h004: return 32'hFFCFFEDC;  'h008: return 32'hF3F40000;
         'h00C: return 32'h19FC3E8B;  'h01C: return 32'h00026108;
         'h020: return 32'h00030291;  'h024: return 32'h00000291;
         'h02C: return 32'h00000010;  'h030: return 32'h20001A03;
         'h034: return 32'h20001A03;  'h038: return 32'h04000030;
         'h03C: return 32'h00000001;  'h040: return 32'h000000C0;
         'h04C: return 32'h00000023;  'h070: return SA;
         'h074: return 32'h0000000E;  'h07C: return REVV;
         'h084: return 32'h0000F000;  'h088: return 32'h01000000;
         'h08C: return 32'h000000FF;  'h090: return 32'h0000A000;
         'h09C: return 32'h003FFFF3;  'h0A4: return 32'hFFFF0000;
         'h0A8: return 32'h000FFFFF;  'h0D0: return SB;
         'h0E0: return 32'h000000FF;  'h0E4: return 32'h000000FF;
         'h104: return 32'h80000000;  'h110: return 32'h1E600000;
         'h114: return 32'hC0000000;  'h160: return 32'h00001903;
         'h180: return 32'h0000007B;  'h1A4: return 32'h00002402;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit ref_ro(int a);
      return a == 5 || (a >= 20 && a <= 27) || a == 30 || a == 31 ||
             a == 56 || a == 57;
   endfunction

   task automatic compare();
      checks++;
      if (rdata !== exp_rdata || err !== exp_err) begin
         errors++;
         $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                  prev_tag, rdata, err, exp_rdata, exp_err);
      end
   endtask

   // compare last cycle's result, then drive and predict the next one
   task automatic step(bit s, bit w, int a, logic [31:0] d, string tag);
      bit ok;
      @(negedge clk);
      compare();
      sel = s; wr = w; addr = 8'(a); wdata = d;
      prev_tag = tag;
      if (s && w) begin
         ok = a < NREG && !ref_ro(a) &&
              !(a >= 1 && a < 65 && mdl[0] != KEYV);
         if (ok) mdl[a] = d;
         exp_err = !ok;
      end else if (s) begin
         exp_rdata = (a < NREG) ? mdl[a] : 32'h0;
         exp_err   = (a >= NREG) || a == 48;
      end else begin
         exp_err = 0;
      end
   endtask

   task automatic wr_(int a, logic [31:0] d, string tag); step(1, 1, a, d, tag); endtask
   task automatic rd_(int a, string tag); step(1, 0, a, '0, tag); endtask
   task automatic idle(string tag); step(0, 0, 0, '0, tag); endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) mdl[i] = ref_rst(i);
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      idle("R8 reset state");
      // full read-back after reset: table constants, revision and straps
      for (int i = 0; i < NREG; i++)
         rd_(i, (i == 28 || i == 31 || i == 52) ? "R2 strap/revision" : "R1 reset value");
      // locked: protected writes refused, open range accepted
      wr_(1, 32'h1111_2222, "R3 locked write");
      wr_(64, 32'h3333_4444, "R3 locked write top");
      rd_(1, "R3 locked keeps value");
      rd_(64, "R3 locked keeps value");
      wr_(65, 32'h5555_6666, "R4 open write");
      wr_(105, 32'h7777_8888, "R4 open write last");
      rd_(65, "R4 open readback");
      rd_(105, "R4 open readback");
      // unlock
      wr_(0, KEYV, "R4 key write");
      wr_(1, 32'h1111_2222, "R3 unlocked write");
      rd_(1, "R3 unlocked readback");
      wr_(64, 32'h3333_4444, "R3 unlocked write top");
      rd_(64, "R3 unlocked readback");
      wr_(28, 32'hCAFE_0028, "R3 strap slot write");
      rd_(28, "R3 strap readback");
      // read-only slots
      wr_(5, 32'hDEAD_0005, "R5 ro write");
      wr_(20, 32'hDEAD_0020, "R5 ro write");
      wr_(27, 32'hDEAD_0027, "R5 ro write");
      wr_(31, 32'hDEAD_0031, "R5 ro write rev");
      wr_(56, 32'hDEAD_0056, "R5 ro write");
      rd_(5, "R5 ro unchanged");
      rd_(31, "R5 ro unchanged");
      rd_(56, "R5 ro unchanged");
      // write-only slot
      wr_(48, 32'hBEEF_0048, "R6 wo write");
      rd_(48, "R6 wo read flagged");
      // out of range
      rd_(106, "R7 oob read");
      rd_(255, "R7 oob read");
      wr_(106, 32'h0BAD_0BAD, "R7 oob write");
      rd_(105, "R7 oob write no effect");
      // idle holds
      idle("R9 idle");
      idle("R9 idle");
      // back-to-back write then read
      wr_(70, 32'h1234_5678, "R8 write");
      rd_(70, "R8 next-cycle read");
      wr_(70, 32'h8765_4321, "R8 write");
      rd_(70, "R8 next-cycle read");
      // sweep while unlocked
      for (int i = 1; i < NREG; i++)
         wr_(i, (32'(i) * 32'h0101_0101) ^ 32'hF0F0_0000,
             ref_ro(i) ? "R5 sweep write" : "R4 sweep write");
      for (int i = 0; i < NREG; i++)
         rd_(i, ref_ro(i) ? "R5 sweep read" : "R3 sweep read");
      // relock
      wr_(0, 32'h0000_0001, "R4 relock key write");
      wr_(2, 32'h2222_2222, "R3 relocked write");
      rd_(2, "R3 relocked keeps value");
      wr_(0, KEYV, "R4 key write");
      wr_(2, 32'h2222_2222, "R3 re-unlocked write");
      rd_(2, "R3 re-unlocked readback");
      idle("R9 idle");
      idle("R9 final");
      @(negedge clk);
      compare();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

endmodule